// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit linear address to a 32-bit physical address when a translation cache has missed. It reads a directory entry and then a page table entry from memory through a simple synchronous word port. It checks each entry for presence and checks the combined access permissions against the request. Where needed, it writes back the accessed and dirty flags.

A successful walk returns the physical address together with the dirty, user and writable attributes that a cache fill needs. A walk that hits a missing entry or breaks a permission rule ends with a fault indication, and the linear address is recorded in a fault-address register. The directory base register is loaded through a dedicated write strobe.

The walker handles one request at a time. It is ready only when idle, and it ignores request strobes while a walk is in progress.

Top module: `pgwalk_top`

## Requirements
- R1: Loading the directory base keeps only bits 31:12 and forces bits 11:0 to zero. The first memory access after a request is accepted is a read at base + linear[31:22]*4, issued in the cycle after acceptance.
- R2: The table entry is read at {directory entry[31:12], 12'h000} + linear[21:12]*4.
- R3: A successful walk returns {table entry[31:12], linear[11:0]} with rsp_done high for exactly one cycle. With base 0x00010000 and linear 0x0301008A, the directory read is at 0x00010030, the table read is at 0x05001040 when that entry holds frame 0x05001, and the result is 0x0300008A when the table entry holds frame 0x03000.
- R4: If the present bit (bit 0) is clear in the directory entry or in the table entry, the walk ends with rsp_done and rsp_fault both high. After a missing directory entry, no table read is made.
- R5: When the accessed bit (bit 5) of a present directory entry is clear, the entry is written back with bit 5 set. No write is made when bit 5 is already set.
- R6: For a permitted access, the table entry is written back with bit 5 set, and also with the dirty bit (bit 6) set when the access is a write. The write-back happens only if this changes the entry.
- R7: A user access faults when the combined user bit (bit 2 of both entries ANDed) is 0. A user write faults when the combined writable bit (bit 1 of both entries ANDed) is 0. Supervisor accesses never fault on these bits. A faulting walk writes nothing back to the table entry.
- R8: On success, rsp_dirty is bit 6 of the table entry after update, rsp_user is the combined bit 2, and rsp_rw is the combined bit 1.
- R9: req_ready is high only while idle. A request strobe during a walk has no effect. mem_we is only high together with mem_req. Read data is taken from mem_rdata one cycle after the read request.
- R10: fault_addr takes the linear address of a faulting walk and keeps its value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Load strobe for the directory base register |
| base_wdata | input | 32 | New directory base (bits 11:0 discarded) |
| req_valid | input | 1 | Walk request strobe |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is from user mode |
| mem_req | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address of the entry |
| mem_wdata | output | 32 | Updated entry for write-back |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| rsp_done | output | 1 | Walk finished (one-cycle pulse) |
| rsp_fault | output | 1 | Walk ended in a page fault |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_dirty | output | 1 | Dirty attribute for the cache fill |
| rsp_user | output | 1 | Combined user-access attribute |
| rsp_rw | output | 1 | Combined writable attribute |
| fault_addr | output | 32 | Linear address of the latest page fault |

## Verification
The hardest case to reach is a permission fault that happens after the directory entry has already been written back but before any table-entry update. Only a particular history of memory contents puts the walker there. The stimulus reaches it by first sending a supervisor walk through a fresh directory entry whose user bit is clear, and then sending a user access to a neighbouring page under that same entry. A request strobe is also injected in the middle of a walk, to show that it neither changes the bus sequence nor starts a second walk.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int ENT_P  = 0;
  localparam int ENT_RW = 1;
  localparam int ENT_US = 2;
  localparam int ENT_A  = 5;
  localparam int ENT_D  = 6;

  typedef enum logic [3:0] {
    W_IDLE, W_DIR_RD, W_DIR_CHK, W_DIR_WB,
    W_TBL_RD, W_TBL_CHK, W_TBL_WB, W_DONE, W_FAULT
  } walk_state_e;
endpackage

// File: rtl/pgwalk_addr.sv
module pgwalk_addr #(
  parameter int DIR_W = 10,
  parameter int TBL_W = 10,
  parameter int OFF_W = 12,
  parameter int ENT_SH = 2,
  localparam int VA_W = DIR_W + TBL_W + OFF_W,
  localparam int FRAME_W = VA_W - OFF_W
) (
  input  logic [FRAME_W-1:0] base_frame,
  input  logic [FRAME_W-1:0] dir_frame,
  input  logic [FRAME_W-1:0] tbl_frame,
  input  logic [VA_W-1:0]    lin,
  output logic [VA_W-1:0]    dir_ent_addr,
  output logic [VA_W-1:0]    tbl_ent_addr,
  output logic [VA_W-1:0]    phys_addr
);
  logic [DIR_W-1:0] dir_idx;
  logic [TBL_W-1:0] tbl_idx;
  logic [OFF_W-1:0] page_off;

  assign dir_idx  = lin[VA_W-1 -: DIR_W];
  assign tbl_idx  = lin[OFF_W +: TBL_W];
  assign page_off = lin[OFF_W-1:0];

  assign dir_ent_addr = {base_frame, {OFF_W{1'b0}}} + (VA_W'(dir_idx) << ENT_SH);
  assign tbl_ent_addr = {dir_frame, {OFF_W{1'b0}}} + (VA_W'(tbl_idx) << ENT_SH);
  assign phys_addr    = {tbl_frame, page_off};
endmodule

// File: rtl/pgwalk_eval.sv
module pgwalk_eval #(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             leaf,
  input  logic             acc_write,
  input  logic             acc_user,
  input  logic             dir_us,
  input  logic             dir_rw,
  output logic             present,
  output logic             prot_fault,
  output logic             eff_us,
  output logic             eff_rw,
  output logic [ENT_W-1:0] upd_entry,
  output logic             upd_needed
);
  import pgwalk_pkg::*;

  logic [ENT_W-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[ENT_A] = 1'b1;
    if (leaf && acc_write) set_mask[ENT_D] = 1'b1;
  end

  assign present    = entry[ENT_P];
  assign eff_us     = dir_us & entry[ENT_US];
  assign eff_rw     = dir_rw & entry[ENT_RW];
  assign prot_fault = leaf && acc_user && (!eff_us || (acc_write && !eff_rw));
  assign upd_entry  = entry | set_mask;
  assign upd_needed = (upd_entry != entry);
endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
  parameter int DIR_IDX_W  = 10,
  parameter int TBL_IDX_W  = 10,
  parameter int PAGE_OFF_W = 12,
  localparam int VA_W    = DIR_IDX_W + TBL_IDX_W + PAGE_OFF_W,
  localparam int FRAME_W = VA_W - PAGE_OFF_W,
  localparam int ENT_SH  = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            base_we,
  input  logic [VA_W-1:0] base_wdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_lin,
  input  logic            req_write,
  input  logic            req_user,
  output logic            mem_req,
  output logic            mem_we,
  output logic [VA_W-1:0] mem_addr,
  output logic [VA_W-1:0] mem_wdata,
  input  logic [VA_W-1:0] mem_rdata,
  output logic            rsp_done,
  output logic            rsp_fault,
  output logic [VA_W-1:0] rsp_paddr,
  output logic            rsp_dirty,
  output logic            rsp_user,
  output logic            rsp_rw,
  output logic [VA_W-1:0] fault_addr
);
  import pgwalk_pkg::*;

  walk_state_e        state_q;
  logic [FRAME_W-1:0] base_frame_q;
  logic [FRAME_W-1:0] dir_frame_q;
  logic               dir_us_q, dir_rw_q;
  logic [VA_W-1:0]    lin_q;
  logic               wr_q, usr_q;
  logic [VA_W-1:0]    wdata_q;
  logic [VA_W-1:0]    paddr_q;
  logic               dirty_q, user_q, rw_q;
  logic [VA_W-1:0]    fault_q;

  logic [VA_W-1:0] dir_ent_addr, tbl_ent_addr, phys_addr;
  logic            ent_present, ent_prot_fault, ent_eff_us, ent_eff_rw, ent_upd_needed;
  logic [VA_W-1:0] ent_upd;
  logic            at_leaf;
  logic            unused_base_lo;

  assign unused_base_lo = ^base_wdata[PAGE_OFF_W-1:0];
  assign at_leaf = (state_q == W_TBL_CHK);

  pgwalk_addr #(
    .DIR_W(DIR_IDX_W), .TBL_W(TBL_IDX_W), .OFF_W(PAGE_OFF_W), .ENT_SH(ENT_SH)
  ) u_addr (
    .base_frame  (base_frame_q),
    .dir_frame   (dir_frame_q),
    .tbl_frame   (mem_rdata[VA_W-1:PAGE_OFF_W]),
    .lin         (lin_q),
    .dir_ent_addr(dir_ent_addr),
    .tbl_ent_addr(tbl_ent_addr),
    .phys_addr   (phys_addr)
  );

  pgwalk_eval #(.ENT_W(VA_W)) u_eval (
    .entry     (mem_rdata),
    .leaf      (at_leaf),
    .acc_write (wr_q),
    .acc_user  (usr_q),
    .dir_us    (dir_us_q),
    .dir_rw    (dir_rw_q),
    .present   (ent_present),
    .prot_fault(ent_prot_fault),
    .eff_us    (ent_eff_us),
    .eff_rw    (ent_eff_rw),
    .upd_entry (ent_upd),
    .upd_needed(ent_upd_needed)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_frame_q <= '0;
    end else if (base_we) begin
      base_frame_q <= base_wdata[VA_W-1:PAGE_OFF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= W_IDLE;
      dir_frame_q <= '0;
      dir_us_q    <= 1'b0;
      dir_rw_q    <= 1'b0;
      lin_q       <= '0;
      wr_q        <= 1'b0;
      usr_q       <= 1'b0;
      wdata_q     <= '0;
      paddr_q     <= '0;
      dirty_q     <= 1'b0;
      user_q      <= 1'b0;
      rw_q        <= 1'b0;
      fault_q     <= '0;
    end else begin
      unique case (state_q)
        W_IDLE: begin
          if (req_valid) begin
            lin_q   <= req_lin;
            wr_q    <= req_write;
            usr_q   <= req_user;
            state_q <= W_DIR_RD;
          end
        end
        W_DIR_RD: state_q <= W_DIR_CHK;
        W_DIR_CHK: begin
          dir_frame_q <= mem_rdata[VA_W-1:PAGE_OFF_W];
          dir_us_q    <= mem_rdata[ENT_US];
          dir_rw_q    <= mem_rdata[ENT_RW];
          if (!ent_present) begin
            fault_q <= lin_q;
            state_q <= W_FAULT;
          end else if (ent_upd_needed) begin
            wdata_q <= ent_upd;
            state_q <= W_DIR_WB;
          end else begin
            state_q <= W_TBL_RD;
          end
        end
        W_DIR_WB: state_q <= W_TBL_RD;
        W_TBL_RD: state_q <= W_TBL_CHK;
        W_TBL_CHK: begin
          if (!ent_present || ent_prot_fault) begin
            fault_q <= lin_q;
            state_q <= W_FAULT;
          end else begin
            paddr_q <= phys_addr;
            dirty_q <= ent_upd[ENT_D];
            user_q  <= ent_eff_us;
            rw_q    <= ent_eff_rw;
            if (ent_upd_needed) begin
              wdata_q <= ent_upd;
              state_q <= W_TBL_WB;
            end else begin
              state_q <= W_DONE;
            end
          end
        end
        W_TBL_WB: state_q <= W_DONE;
        W_DONE:   state_q <= W_IDLE;
        W_FAULT:  state_q <= W_IDLE;
        default:  state_q <= W_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = dir_ent_addr;
    unique case (state_q)
      W_DIR_RD: mem_req = 1'b1;
      W_DIR_WB: begin mem_req = 1'b1; mem_we = 1'b1; end
      W_TBL_RD: begin mem_req = 1'b1; mem_addr = tbl_ent_addr; end
      W_TBL_WB: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = tbl_ent_addr; end
      default: ;
    endcase
  end

  assign mem_wdata  = wdata_q;
  assign req_ready  = (state_q == W_IDLE);
  assign rsp_done   = (state_q == W_DONE) || (state_q == W_FAULT);
  assign rsp_fault  = (state_q == W_FAULT);
  assign rsp_paddr  = paddr_q;
  assign rsp_dirty  = dirty_q;
  assign rsp_user   = user_q;
  assign rsp_rw     = rw_q;
  assign fault_addr = fault_q;
endmodule

// File: rtl/pgwalk_props.sv
module pgwalk_props #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req,
  input logic            mem_we,
  input logic            wb_acc_bit,
  input logic            wb_pres_bit,
  input logic            rsp_done,
  input logic            rsp_fault,
  input logic [VA_W-1:0] fault_addr
);
  assert_we_with_req_R9: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !req_ready);

  assert_accept_reads_dir_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_req && !mem_we));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  assert_fault_with_done_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_done);

  assert_wb_sets_accessed_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (wb_acc_bit && wb_pres_bit));

  assert_fault_addr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !$stable(fault_addr) |-> rsp_fault);
endmodule

bind pgwalk_top pgwalk_props #(.VA_W(VA_W)) u_props (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .wb_acc_bit (mem_wdata[pgwalk_pkg::ENT_A]),
  .wb_pres_bit(mem_wdata[pgwalk_pkg::ENT_P]),
  .rsp_done   (rsp_done),
  .rsp_fault  (rsp_fault),
  .fault_addr (fault_addr)
);

// File: tb/test_pgwalk_top.sv
module test_pgwalk_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic        req_write = 1'b0;
  logic        req_user = 1'b0;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        rsp_done, rsp_fault, rsp_dirty, rsp_user, rsp_rw;
  logic [31:0] rsp_paddr, fault_addr;

  pgwalk_top i_pgwalk_top (
    .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_lin(req_lin),
    .req_write(req_write), .req_user(req_user),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
    .rsp_dirty(rsp_dirty), .rsp_user(rsp_user), .rsp_rw(rsp_rw),
    .fault_addr(fault_addr)
  );

  logic [31:0] mem [logic [31:0]];

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a)) return mem[a];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] = mem_wdata;
      else mem_rdata <= rd(mem_addr);
    end
  end

  typedef struct {
    bit req; bit we; logic [31:0] addr; logic [31:0] wdata;
    bit done; bit fault; logic [31:0] paddr; bit d; bit us; bit rw;
    string tag;
  } cyc_t;

  cyc_t        exp_q[$];
  int          checks = 0;
  int          errors = 0;
  logic [31:0] base_m = '0;
  logic [31:0] exp_fault = '0;
  bit          finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic cyc_t idle(input string tag);
    cyc_t c;
    c.req = 0; c.we = 0; c.addr = '0; c.wdata = '0; c.done = 0; c.fault = 0;
    c.paddr = '0; c.d = 0; c.us = 0; c.rw = 0; c.tag = tag;
    return c;
  endfunction

  function automatic cyc_t bus(input bit we, input logic [31:0] a,
                               input logic [31:0] wd, input string tag);
    cyc_t c = idle(tag);
    c.req = 1; c.we = we; c.addr = a; c.wdata = wd;
    return c;
  endfunction

  // Behavioural reference: expected per-cycle bus and response activity
  task automatic predict(input logic [31:0] lin, input bit wr, input bit usr);
    logic [31:0] pa, pde, ta, pte, npte;
    cyc_t c;
    bit us, rw;
    exp_q.delete();
    pa  = base_m + {20'h0, lin[31:22], 2'b00};
    pde = rd(pa);
    exp_q.push_back(bus(0, pa, '0, "R1"));
    exp_q.push_back(idle("R1"));
    if (!pde[0]) begin
      c = idle("R4"); c.done = 1; c.fault = 1; exp_q.push_back(c);
      exp_fault = lin; return;
    end
    if (!pde[5]) exp_q.push_back(bus(1, pa, pde | 32'h20, "R5"));
    ta  = {pde[31:12], 12'h0} + {20'h0, lin[21:12], 2'b00};
    pte = rd(ta);
    exp_q.push_back(bus(0, ta, '0, "R2"));
    exp_q.push_back(idle("R2"));
    if (!pte[0]) begin
      c = idle("R4"); c.done = 1; c.fault = 1; exp_q.push_back(c);
      exp_fault = lin; return;
    end
    us = pde[2] & pte[2];
    rw = pde[1] & pte[1];
    if (usr && (!us || (wr && !rw))) begin
      c = idle("R7"); c.done = 1; c.fault = 1; exp_q.push_back(c);
      exp_fault = lin; return;
    end
    npte = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
    if (npte != pte) exp_q.push_back(bus(1, ta, npte, "R6"));
    c = idle("R3"); c.done = 1; c.paddr = {pte[31:12], lin[11:0]};
    c.d = npte[6]; c.us = us; c.rw = rw;
    exp_q.push_back(c);
  endtask

  task automatic walk(input logic [31:0] lin, input bit wr, input bit usr, input bit poke);
    cyc_t c;
    int n;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready before request", {31'h0, req_ready}, 32'h1);
    predict(lin, wr, usr);
    req_valid = 1; req_lin = lin; req_write = wr; req_user = usr;
    @(posedge clk); #1;
    req_valid = 0;
    n = exp_q.size();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c = exp_q[i];
      chk(mem_req == c.req, c.tag, "mem_req", {31'h0, mem_req}, {31'h0, c.req});
      if (c.req) begin
        chk(mem_we == c.we, c.tag, "mem_we", {31'h0, mem_we}, {31'h0, c.we});
        chk(mem_addr == c.addr, c.tag, "mem_addr", mem_addr, c.addr);
        if (c.we) chk(mem_wdata == c.wdata, c.tag, "mem_wdata", mem_wdata, c.wdata);
      end
      chk(req_ready == 1'b0, "R9", "ready while busy", {31'h0, req_ready}, 32'h0);
      chk(rsp_done == c.done, c.tag, "rsp_done", {31'h0, rsp_done}, {31'h0, c.done});
      if (c.done) begin
        chk(rsp_fault == c.fault, c.tag, "rsp_fault", {31'h0, rsp_fault}, {31'h0, c.fault});
        if (c.fault)
          chk(fault_addr == lin, "R10", "fault_addr", fault_addr, lin);
        else begin
          chk(rsp_paddr == c.paddr, "R3", "rsp_paddr", rsp_paddr, c.paddr);
          chk({rsp_dirty, rsp_user, rsp_rw} == {c.d, c.us, c.rw}, "R8", "attrs",
              {29'h0, rsp_dirty, rsp_user, rsp_rw}, {29'h0, c.d, c.us, c.rw});
        end
      end
      if (poke && i == 0) begin
        req_valid = 1; req_lin = 32'hFFFFF123; req_write = 1; req_user = 1;
      end
      if (poke && i == 2) req_valid = 0;
    end
    @(negedge clk);
    chk(mem_req == 1'b0 && rsp_done == 1'b0, "R9", "idle after walk",
        {30'h0, mem_req, rsp_done}, 32'h0);
    chk(fault_addr == exp_fault, "R10", "fault_addr held", fault_addr, exp_fault);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R9 watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mem[32'h00010030] = 32'h05001007;
    mem[32'h05001040] = 32'h03000007;
    mem[32'h00010044] = 32'h06000003;
    mem[32'h06000018] = 32'h07000007;
    mem[32'h00010048] = 32'h08000007;
    mem[32'h08000000] = 32'h09000005;

    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(req_ready == 1 && mem_req == 0 && rsp_done == 0, "R9", "reset state",
        {29'h0, req_ready, mem_req, rsp_done}, 32'h4);
    chk(fault_addr == 32'h0, "R10", "reset fault_addr", fault_addr, 32'h0);

    // R1: low bits of the base are discarded
    base_we = 1; base_wdata = 32'h00010ABC;
    @(posedge clk); #1 base_we = 0;
    base_m = 32'h00010000;

    walk(32'h0301008A, 0, 0, 0);                         // R3 worked example
    chk(rd(32'h00010030) == 32'h05001027, "R5", "dir entry A set", rd(32'h00010030), 32'h05001027);
    chk(rd(32'h05001040) == 32'h03000027, "R6", "tbl entry A set", rd(32'h05001040), 32'h03000027);
    walk(32'h0301008A, 1, 0, 0);                         // R6 dirty on write
    chk(rd(32'h05001040) == 32'h03000067, "R6", "tbl entry D set", rd(32'h05001040), 32'h03000067);
    walk(32'h0301008A, 1, 1, 0);                         // no write-back needed
    walk(32'h04010000, 0, 0, 0);                         // R4 missing dir entry
    walk(32'h04405123, 0, 0, 0);                         // R4 missing tbl entry
    walk(32'h04406ABC, 0, 1, 0);                         // R7 user on supervisor page
    chk(rd(32'h06000018) == 32'h07000007, "R7", "no wb on fault", rd(32'h06000018), 32'h07000007);
    walk(32'h04406ABC, 0, 0, 0);                         // R8 supervisor ok, us=0
    walk(32'h04800010, 1, 1, 0);                         // R7 user write read-only
    chk(rd(32'h08000000) == 32'h09000005, "R7", "no wb on write fault", rd(32'h08000000), 32'h09000005);
    walk(32'h04800010, 0, 1, 0);                         // R8 rw=0 read ok
    walk(32'h04800010, 1, 0, 0);                         // R7 supervisor write ok
    walk(32'h0301008A, 0, 1, 1);                         // R9 strobe while busy ignored
    repeat (3) begin
      @(negedge clk);
      chk(mem_req == 0 && rsp_done == 0, "R9", "no stray walk", {30'h0, mem_req, rsp_done}, 32'h0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule